// File: doc/BRIEF.md
# Two-Channel Bus Breakpoint Comparator

This block is a debug breakpoint unit that watches the processor's buses and raises a break request when a programmed condition is seen. The processor side has an instruction-fetch address bus and a memory-access bus that carries both address and data. A third internal bus also carries address and data. Each of the two channels chooses one address source and one data source. It then checks the chosen bus cycle against a masked address, an optional masked data value, the cycle kind, the transfer direction and the operand size. A channel matches only when all of its active conditions hold in the same clock cycle.

A match sets a sticky per-channel flag. Software clears that flag by writing a 1 to the matching bit of a status address. The break request stays high while any flag is set. Every event that sets a flag also produces a one-clock trigger pulse on a pin. For instruction-fetch matches, a per-channel setting chooses when the break is reported:

- **Before execution:** the break is reported at the fetch itself.
- **After execution:** the unit holds the fetch address. It sets the flag only when an instruction-retire strobe with that same address arrives.

A configuration write takes effect from the cycle after the write. A bus cycle in the same clock is still compared against the old settings.

Top module: `dbg_break_unit`

## Requirements
- R1: After reset every flag, after-execution indicator, the break request and the trigger are 0, and every channel is disabled.
- R2: Channel c has its registers at config addresses c*8+0 (address value), c*8+1 (address ignore mask), c*8+2 (data value), c*8+3 (data ignore mask) and c*8+4 (control). Address bits whose ignore-mask bit is 1 play no part in the compare. Any mismatch in an unmasked bit prevents a match.
- R3: Control bits [2:1] pick the observed bus: 0 is the fetch bus, 1 the memory bus, 2 the internal bus, and 3 never matches. Only a valid cycle on the picked bus is examined.
- R4: Control bit 4 enables the data compare; when it is 0, data is a don't-care. Control bit 3 picks the data source: 0 is memory data, 1 is internal data. Data bits with a 1 in the data ignore mask are ignored.
- R5: Control bits [6:5] give the cycle kind: 0 is any, 1 is instruction fetch, 2 is data access, and 3 never matches. Only fetch-bus cycles count as fetches, so the fetch kind can never match on the internal bus.
- R6: Control bits [8:7] give the direction: 0 is any, 1 is read, 2 is write, and 3 never matches. The bus write strobe is 1 for a write, and fetch cycles count as reads.
- R7: Control bits [10:9] give the size: 0 is any, 1 is byte, 2 is word, and 3 is longword. The bus size code is 0 for byte, 1 for word and 2 for longword. Fetch cycles count as longword.
- R8: A flag goes high at the clock edge that samples its event and then holds. A write to address 16 with bit c set clears flag c and after-execution indicator c. If a set and a clear occur in the same cycle, the set wins. The break request is the OR of the flags.
- R9: Each channel sets only its own flag, from its own settings.
- R10: When control bit 11 is 0, a fetch match is reported at once. When it is 1, the fetch address is held, and the flag is set by a later retire strobe carrying the same address, which consumes the held entry. After-execution indicator c is 1 exactly when flag c was last set by a retire. Data-access matches are always reported at once.
- R11: The trigger is high for exactly one clock, in the cycle after each flag-setting event. Back-to-back events give back-to-back pulses.
- R12: A config write in the same cycle as a bus cycle does not affect that cycle's compare. The new value applies from the next cycle.
- R13: Control bit 0 enables the channel. A disabled channel never matches and drops any held after-execution entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | CFG_AW | Config word address |
| cfg_wdata | input | REG_W | Config write data |
| f_valid | input | 1 | Fetch bus cycle valid |
| f_addr | input | ADDR_W | Fetch bus address |
| m_valid | input | 1 | Memory bus cycle valid |
| m_addr | input | ADDR_W | Memory bus address |
| m_data | input | DATA_W | Memory bus data |
| m_wr | input | 1 | Memory bus write (1) or read (0) |
| m_size | input | 2 | Memory bus size code |
| i_valid | input | 1 | Internal bus cycle valid |
| i_addr | input | ADDR_W | Internal bus address |
| i_data | input | DATA_W | Internal bus data |
| i_wr | input | 1 | Internal bus write (1) or read (0) |
| i_size | input | 2 | Internal bus size code |
| ret_valid | input | 1 | Instruction retire strobe |
| ret_addr | input | ADDR_W | Address of retiring instruction |
| brk_flag | output | NUM_CH | Sticky per-channel match flags |
| brk_req | output | 1 | Break request, OR of flags |
| brk_after | output | NUM_CH | Flag came from an after-execution fetch break |
| trig_out | output | 1 | One-clock trigger pulse per event |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:

- **Masked versus unmasked mismatches:** a compare that ignored the mask, or applied it inverted, would raise flags on the unmasked case or miss the masked one.
- **Cross-bus selection:** cycles are driven on a bus that is not selected, and the data source is chosen separately from the address bus. A wrong multiplexer would match on the wrong traffic.
- **Fetch kind on the internal bus:** this combination must never match.
- **After-execution fetch breaks:** retires with a foreign address and a repeated retire are driven. A design without the held-address slot would flag on the fetch itself or fire twice.
- **Set and clear in one cycle:** a design with the wrong priority would lose the event.
- **Config write during a matching cycle:** a design that let the new value through at once would miss the event.

// File: rtl/dbg_break_pkg.sv
package dbg_break_pkg;

   // config map layout
   localparam int REGS_PER_CH = 8;
   localparam int OFS_ADDR    = 0;
   localparam int OFS_AMSK    = 1;
   localparam int OFS_DATA    = 2;
   localparam int OFS_DMSK    = 3;
   localparam int OFS_CTRL    = 4;
   localparam int CTRL_W      = 12;

   // bus size codes
   localparam logic [1:0] BSZ_BYTE = 2'd0;
   localparam logic [1:0] BSZ_WORD = 2'd1;
   localparam logic [1:0] BSZ_LONG = 2'd2;

   typedef enum logic [1:0] {
      ASRC_FETCH = 2'd0,
      ASRC_MEM   = 2'd1,
      ASRC_INT   = 2'd2,
      ASRC_NONE  = 2'd3
   } asrc_e;

   typedef enum logic [1:0] {
      KIND_ANY   = 2'd0,
      KIND_FETCH = 2'd1,
      KIND_DATA  = 2'd2,
      KIND_NEVER = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      DIR_ANY   = 2'd0,
      DIR_RD    = 2'd1,
      DIR_WR    = 2'd2,
      DIR_NEVER = 2'd3
   } dir_e;

   typedef enum logic [1:0] {
      SZC_ANY  = 2'd0,
      SZC_BYTE = 2'd1,
      SZC_WORD = 2'd2,
      SZC_LONG = 2'd3
   } szc_e;

   // control word, MSB first: bit 11 down to bit 0
   typedef struct packed {
      logic  after;   // 11
      szc_e  size;    // 10:9
      dir_e  dir;     // 8:7
      kind_e kind;    // 6:5
      logic  den;     // 4
      logic  dsel;    // 3
      asrc_e asel;    // 2:1
      logic  en;      // 0
   } ctrl_t;

endpackage

// File: rtl/dbg_break_cfg.sv
module dbg_break_cfg
   import dbg_break_pkg::*;
#(
   parameter int CH     = 0,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int REG_W  = 32,
   parameter int CFG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [CFG_AW-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output ctrl_t             ctrl,
   output logic [ADDR_W-1:0] addr_val,
   output logic [ADDR_W-1:0] addr_msk,
   output logic [DATA_W-1:0] data_val,
   output logic [DATA_W-1:0] data_msk
);

   localparam int BASE = CH * REGS_PER_CH;
   localparam logic [CFG_AW-1:0] A_ADDR = CFG_AW'(BASE + OFS_ADDR);
   localparam logic [CFG_AW-1:0] A_AMSK = CFG_AW'(BASE + OFS_AMSK);
   localparam logic [CFG_AW-1:0] A_DATA = CFG_AW'(BASE + OFS_DATA);
   localparam logic [CFG_AW-1:0] A_DMSK = CFG_AW'(BASE + OFS_DMSK);
   localparam logic [CFG_AW-1:0] A_CTRL = CFG_AW'(BASE + OFS_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         addr_val <= '0;
         addr_msk <= '0;
         data_val <= '0;
         data_msk <= '0;
      end else if (we) begin
         if (addr == A_ADDR) addr_val <= wdata[ADDR_W-1:0];
         if (addr == A_AMSK) addr_msk <= wdata[ADDR_W-1:0];
         if (addr == A_DATA) data_val <= wdata[DATA_W-1:0];
         if (addr == A_DMSK) data_msk <= wdata[DATA_W-1:0];
         if (addr == A_CTRL) ctrl     <= ctrl_t'(wdata[CTRL_W-1:0]);
      end
   end

endmodule

// File: rtl/dbg_break_cmp.sv
module dbg_break_cmp
   import dbg_break_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  ctrl_t             ctrl,
   input  logic [ADDR_W-1:0] addr_val,
   input  logic [ADDR_W-1:0] addr_msk,
   input  logic [DATA_W-1:0] data_val,
   input  logic [DATA_W-1:0] data_msk,
   input  logic              f_valid,
   input  logic [ADDR_W-1:0] f_addr,
   input  logic              m_valid,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic [DATA_W-1:0] m_data,
   input  logic              m_wr,
   input  logic [1:0]        m_size,
   input  logic              i_valid,
   input  logic [ADDR_W-1:0] i_addr,
   input  logic [DATA_W-1:0] i_data,
   input  logic              i_wr,
   input  logic [1:0]        i_size,
   output logic              hit,
   output logic              is_fetch,
   output logic [ADDR_W-1:0] obs_addr
);

   logic              obs_valid;
   logic              obs_wr;
   logic [1:0]        obs_size;
   logic [DATA_W-1:0] obs_data;
   logic              addr_ok, data_ok, kind_ok, dir_ok, size_ok;

   // pick the observed cycle
   always_comb begin
      case (ctrl.asel)
         ASRC_FETCH: begin
            obs_valid = f_valid; obs_addr = f_addr;
            obs_wr = 1'b0; obs_size = BSZ_LONG; is_fetch = 1'b1;
         end
         ASRC_MEM: begin
            obs_valid = m_valid; obs_addr = m_addr;
            obs_wr = m_wr; obs_size = m_size; is_fetch = 1'b0;
         end
         ASRC_INT: begin
            obs_valid = i_valid; obs_addr = i_addr;
            obs_wr = i_wr; obs_size = i_size; is_fetch = 1'b0;
         end
         default: begin
            obs_valid = 1'b0; obs_addr = '0;
            obs_wr = 1'b0; obs_size = BSZ_LONG; is_fetch = 1'b0;
         end
      endcase
   end

   assign obs_data = ctrl.dsel ? i_data : m_data;

   assign addr_ok = ((obs_addr ^ addr_val) & ~addr_msk) == '0;
   assign data_ok = !ctrl.den || (((obs_data ^ data_val) & ~data_msk) == '0);

   always_comb begin
      case (ctrl.kind)
         KIND_ANY:   kind_ok = 1'b1;
         KIND_FETCH: kind_ok = is_fetch;
         KIND_DATA:  kind_ok = !is_fetch;
         default:    kind_ok = 1'b0;
      endcase
   end

   always_comb begin
      case (ctrl.dir)
         DIR_ANY: dir_ok = 1'b1;
         DIR_RD:  dir_ok = !obs_wr;
         DIR_WR:  dir_ok = obs_wr;
         default: dir_ok = 1'b0;
      endcase
   end

   always_comb begin
      case (ctrl.size)
         SZC_ANY:  size_ok = 1'b1;
         SZC_BYTE: size_ok = (obs_size == BSZ_BYTE);
         SZC_WORD: size_ok = (obs_size == BSZ_WORD);
         default:  size_ok = (obs_size == BSZ_LONG);
      endcase
   end

   assign hit = ctrl.en && obs_valid && addr_ok && data_ok &&
                kind_ok && dir_ok && size_ok;

endmodule

// File: rtl/dbg_break_track.sv
module dbg_break_track #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              hit,
   input  logic              is_fetch,
   input  logic              after_mode,
   input  logic [ADDR_W-1:0] obs_addr,
   input  logic              ret_valid,
   input  logic [ADDR_W-1:0] ret_addr,
   input  logic              clr,
   output logic              flag,
   output logic              aflag,
   output logic              set_evt
);

   logic              pend;
   logic [ADDR_W-1:0] pend_addr;
   logic              defer, imm, ret_evt;

   assign defer   = hit && is_fetch && after_mode;
   assign imm     = hit && !defer;
   assign ret_evt = en && pend && ret_valid && (ret_addr == pend_addr);
   assign set_evt = imm || ret_evt;

   // held fetch awaiting retire
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_addr <= '0;
      end else if (defer) begin
         pend      <= 1'b1;
         pend_addr <= obs_addr;
      end else if (ret_evt || !en) begin
         pend      <= 1'b0;
      end
   end

   // sticky flag, set beats clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag  <= 1'b0;
         aflag <= 1'b0;
      end else if (set_evt) begin
         flag  <= 1'b1;
         aflag <= ret_evt;
      end else if (clr) begin
         flag  <= 1'b0;
         aflag <= 1'b0;
      end
   end

endmodule

// File: rtl/dbg_break_unit.sv
module dbg_break_unit
   import dbg_break_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int REG_W  = 32,
   parameter int CFG_AW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   input  logic              f_valid,
   input  logic [ADDR_W-1:0] f_addr,
   input  logic              m_valid,
   input  logic [ADDR_W-1:0] m_addr,
   input  logic [DATA_W-1:0] m_data,
   input  logic              m_wr,
   input  logic [1:0]        m_size,
   input  logic              i_valid,
   input  logic [ADDR_W-1:0] i_addr,
   input  logic [DATA_W-1:0] i_data,
   input  logic              i_wr,
   input  logic [1:0]        i_size,
   input  logic              ret_valid,
   input  logic [ADDR_W-1:0] ret_addr,
   output logic [NUM_CH-1:0] brk_flag,
   output logic              brk_req,
   output logic [NUM_CH-1:0] brk_after,
   output logic              trig_out
);

   localparam int STAT_OFS = NUM_CH * REGS_PER_CH;

   // elaboration-time parameter checks
   if (NUM_CH < 1) begin : g_bad_nch
      $error("NUM_CH must be at least 1");
   end
   if (ADDR_W > REG_W || DATA_W > REG_W) begin : g_bad_w
      $error("ADDR_W and DATA_W must not exceed REG_W");
   end
   if (REG_W < CTRL_W || REG_W < NUM_CH) begin : g_bad_rw
      $error("REG_W too narrow for control or status");
   end
   if ((1 << CFG_AW) <= STAT_OFS) begin : g_bad_aw
      $error("CFG_AW too small for the config map");
   end

   logic              stat_wr;
   logic [NUM_CH-1:0] set_vec;

   assign stat_wr = cfg_we && (cfg_addr == CFG_AW'(STAT_OFS));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ctrl_t             ctl;
      logic [ADDR_W-1:0] a_val, a_msk, o_addr;
      logic [DATA_W-1:0] d_val, d_msk;
      logic              hit, isf;

      dbg_break_cfg #(
         .CH(c), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
         .REG_W(REG_W), .CFG_AW(CFG_AW)
      ) u_cfg (
         .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
         .wdata(cfg_wdata), .ctrl(ctl), .addr_val(a_val),
         .addr_msk(a_msk), .data_val(d_val), .data_msk(d_msk)
      );

      dbg_break_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
         .ctrl(ctl), .addr_val(a_val), .addr_msk(a_msk),
         .data_val(d_val), .data_msk(d_msk),
         .f_valid(f_valid), .f_addr(f_addr),
         .m_valid(m_valid), .m_addr(m_addr), .m_data(m_data),
         .m_wr(m_wr), .m_size(m_size),
         .i_valid(i_valid), .i_addr(i_addr), .i_data(i_data),
         .i_wr(i_wr), .i_size(i_size),
         .hit(hit), .is_fetch(isf), .obs_addr(o_addr)
      );

      dbg_break_track #(.ADDR_W(ADDR_W)) u_trk (
         .clk(clk), .rst_n(rst_n), .en(ctl.en), .hit(hit),
         .is_fetch(isf), .after_mode(ctl.after), .obs_addr(o_addr),
         .ret_valid(ret_valid), .ret_addr(ret_addr),
         .clr(stat_wr && cfg_wdata[c]),
         .flag(brk_flag[c]), .aflag(brk_after[c]), .set_evt(set_vec[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_out <= 1'b0;
      else        trig_out <= |set_vec;
   end

   assign brk_req = |brk_flag;

endmodule

// File: rtl/dbg_break_unit_chk.sv
module dbg_break_unit_chk
   import dbg_break_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int CFG_AW = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [NUM_CH-1:0] clr_bits,
   input logic              f_valid,
   input logic              m_valid,
   input logic              i_valid,
   input logic              ret_valid,
   input logic [NUM_CH-1:0] brk_flag,
   input logic              brk_req,
   input logic [NUM_CH-1:0] brk_after,
   input logic              trig_out
);

   logic stat_wr;
   assign stat_wr = cfg_we && (cfg_addr == CFG_AW'(NUM_CH * REGS_PER_CH));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R8: flag holds unless cleared
      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         brk_flag[c] && !(stat_wr && clr_bits[c]) |=> brk_flag[c]);
      // R8: clear drops the flag unless a new event arrived
      p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
         stat_wr && clr_bits[c] |=> (!brk_flag[c] || trig_out));
      // R11: every rise of a flag comes with a trigger pulse
      p_rise_trig_r11: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(brk_flag[c]) |-> trig_out);
      // R9: a flag only rises after bus or retire activity
      p_rise_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(brk_flag[c]) |-> $past(f_valid || m_valid || i_valid || ret_valid));
      // R10: indicator only with its flag
      p_after_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
         brk_after[c] |-> brk_flag[c]);
      // R10: indicator rises only on a retire
      p_after_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(brk_after[c]) |-> $past(ret_valid));
   end

   // R11: trigger leaves a request behind
   p_trig_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      trig_out |-> brk_req);

endmodule

bind dbg_break_unit dbg_break_unit_chk #(
   .NUM_CH(NUM_CH), .CFG_AW(CFG_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .clr_bits(cfg_wdata[NUM_CH-1:0]),
   .f_valid(f_valid), .m_valid(m_valid), .i_valid(i_valid),
   .ret_valid(ret_valid), .brk_flag(brk_flag), .brk_req(brk_req),
   .brk_after(brk_after), .trig_out(trig_out)
);

// File: tb/sim_dbg_break_unit.sv
module sim_dbg_break_unit;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [4:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic        f_valid, m_valid, i_valid, ret_valid;
   logic [31:0] f_addr, m_addr, m_data, i_addr, i_data, ret_addr;
   logic        m_wr, i_wr;
   logic [1:0]  m_size, i_size;
   logic [1:0]  brk_flag, brk_after;
   logic        brk_req, trig_out;

   always #2.5 clk = ~clk;

   dbg_break_unit u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .f_valid(f_valid), .f_addr(f_addr),
      .m_valid(m_valid), .m_addr(m_addr), .m_data(m_data), .m_wr(m_wr),
      .m_size(m_size), .i_valid(i_valid), .i_addr(i_addr), .i_data(i_data),
      .i_wr(i_wr), .i_size(i_size), .ret_valid(ret_valid), .ret_addr(ret_addr),
      .brk_flag(brk_flag), .brk_req(brk_req), .brk_after(brk_after),
      .trig_out(trig_out)
   );

   int checks = 0;
   int errors = 0;
   logic [1:0] ef = 2'b00;   // expected flags
   logic [1:0] ea = 2'b00;   // expected after indicators
   string      tq[$];
   logic [4:0] vq[$];

   localparam logic [31:0] A0 = 32'h1000_0040;
   localparam logic [31:0] A1 = 32'h2000_0000;

   function automatic logic [31:0] ctl(input logic en, input logic [1:0] asel,
      input logic dsel, input logic den, input logic [1:0] kind,
      input logic [1:0] dir, input logic [1:0] sz, input logic aft);
      return {20'd0, aft, sz, dir, kind, den, dsel, asel, en};
   endfunction

   task automatic idle();
      cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      f_valid = 1'b0; m_valid = 1'b0; i_valid = 1'b0; ret_valid = 1'b0;
      m_wr = 1'b0; i_wr = 1'b0; m_size = 2'd2; i_size = 2'd2;
   endtask

   // driver: push expectation for the coming edge, then advance one cycle
   task automatic tick(input string tag, input logic t);
      tq.push_back(tag);
      vq.push_back({ef, ea, t});
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      tick("R2 config write", 1'b0);
   endtask

   task automatic clr(input logic [1:0] mask);
      ef = ef & ~mask; ea = ea & ~mask;
      cfg_we = 1'b1; cfg_addr = 5'd16; cfg_wdata = {30'd0, mask};
      tick("R8 write-1-to-clear", 1'b0);
   endtask

   task automatic mcyc(input logic [31:0] a, input logic [31:0] d,
                       input logic w, input logic [1:0] s);
      m_valid = 1'b1; m_addr = a; m_data = d; m_wr = w; m_size = s;
   endtask

   task automatic icyc(input logic [31:0] a, input logic [31:0] d,
                       input logic w, input logic [1:0] s);
      i_valid = 1'b1; i_addr = a; i_data = d; i_wr = w; i_size = s;
   endtask

   task automatic fcyc(input logic [31:0] a);
      f_valid = 1'b1; f_addr = a;
   endtask

   task automatic hit0(input string tag);
      ef[0] = 1'b1; ea[0] = 1'b0;
      tick(tag, 1'b1);
      tick({tag, " / R11 pulse ends"}, 1'b0);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (vq.size() > 0) begin
            string      tg;
            logic [4:0] v;
            tg = tq.pop_front();
            v  = vq.pop_front();
            checks++;
            if ({brk_flag, brk_after, trig_out} !== v || brk_req !== (|v[4:3])) begin
               errors++;
               $display("FAIL %s: flag/after/trig/req act=%b/%b/%b/%b exp=%b/%b/%b/%b",
                  tg, brk_flag, brk_after, trig_out, brk_req,
                  v[4:3], v[2:1], v[0], |v[4:3]);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      idle();
      f_addr = '0; m_addr = '0; m_data = '0; i_addr = '0; i_data = '0; ret_addr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      checks++;
      if ({brk_flag, brk_after, trig_out, brk_req} !== 6'd0) begin
         errors++;
         $display("FAIL R1 reset state: act=%b exp=000000",
            {brk_flag, brk_after, trig_out, brk_req});
      end
      mcyc(32'h0, 32'h0, 1'b0, 2'd2);
      tick("R1 channels disabled after reset", 1'b0);

      // R2 address mask
      wr(5'd0, A0); wr(5'd1, 32'h0000_000F);
      wr(5'd4, ctl(1, 2'd1, 0, 0, 2'd0, 2'd0, 2'd0, 0));
      mcyc(32'h1000_004A, 32'h0, 1'b0, 2'd2); hit0("R2 masked bits ignored");
      clr(2'b01);
      mcyc(32'h1000_0050, 32'h0, 1'b0, 2'd2); tick("R2 unmasked bit differs", 1'b0);

      // R13 enable
      wr(5'd4, ctl(0, 2'd1, 0, 0, 2'd0, 2'd0, 2'd0, 0));
      mcyc(A0, 32'h0, 1'b0, 2'd2); tick("R13 disabled channel ignores match", 1'b0);

      // R3 address source
      wr(5'd4, ctl(1, 2'd2, 0, 0, 2'd0, 2'd0, 2'd0, 0));
      mcyc(A0, 32'h0, 1'b0, 2'd2); tick("R3 memory bus ignored when internal picked", 1'b0);
      icyc(A0, 32'h0, 1'b0, 2'd2); hit0("R3 internal bus match");
      clr(2'b01);
      wr(5'd4, ctl(1, 2'd0, 0, 0, 2'd0, 2'd0, 2'd0, 0));
      fcyc(A0); hit0("R3 fetch bus match / R10 before-exec");
      clr(2'b01);
      wr(5'd4, ctl(1, 2'd3, 0, 0, 2'd0, 2'd0, 2'd0, 0));
      fcyc(A0); mcyc(A0, 32'h0, 1'b0, 2'd2); icyc(A0, 32'h0, 1'b0, 2'd2);
      tick("R3 source code 3 never matches", 1'b0);

      // R4 data compare
      wr(5'd2, 32'hAABB_CCDD); wr(5'd3, 32'h0000_00FF);
      wr(5'd4, ctl(1, 2'd1, 0, 1, 2'd0, 2'd0, 2'd0, 0));
      mcyc(A0, 32'hAABB_CC00, 1'b0, 2'd2); hit0("R4 masked data bits ignored");
      clr(2'b01);
      mcyc(A0, 32'hAABA_CCDD, 1'b0, 2'd2); tick("R4 data mismatch", 1'b0);
      wr(5'd4, ctl(1, 2'd1, 1, 1, 2'd0, 2'd0, 2'd0, 0));
      mcyc(A0, 32'hAABB_CCDD, 1'b0, 2'd2); i_data = 32'h0;
      tick("R4 memory data ignored when internal data picked", 1'b0);
      mcyc(A0, 32'h0, 1'b0, 2'd2); i_data = 32'hAABB_CCDD;
      hit0("R4 internal data source");
      clr(2'b01);

      // R5 cycle kind
      wr(5'd4, ctl(1, 2'd1, 0, 0, 2'd1, 2'd0, 2'd0, 0));
      mcyc(A0, 32'h0, 1'b0, 2'd2); tick("R5 fetch kind rejects data access", 1'b0);
      wr(5'd4, ctl(1, 2'd0, 0, 0, 2'd2, 2'd0, 2'd0, 0));
      fcyc(A0); tick("R5 data kind rejects fetch", 1'b0);
      wr(5'd4, ctl(1, 2'd0, 0, 0, 2'd1, 2'd0, 2'd0, 0));
      fcyc(A0); hit0("R5 fetch kind on fetch bus");
      clr(2'b01);
      wr(5'd4, ctl(1, 2'd2, 0, 0, 2'd1, 2'd0, 2'd0, 0));
      icyc(A0, 32'h0, 1'b0, 2'd2); tick("R5 fetch kind never on internal bus", 1'b0);
      wr(5'd4, ctl(1, 2'd2, 0, 0, 2'd2, 2'd0, 2'd0, 0));
      icyc(A0, 32'h0, 1'b0, 2'd2); hit0("R5 data kind on internal bus");
      clr(2'b01);

      // R6 direction
      wr(5'd4, ctl(1, 2'd1, 0, 0, 2'd0, 2'd2, 2'd0, 0));
      mcyc(A0, 32'h0, 1'b0, 2'd2); tick("R6 write condition rejects read", 1'b0);
      mcyc(A0, 32'h0, 1'b1, 2'd2); hit0("R6 write matches");
      clr(2'b01);
      wr(5'd4, ctl(1, 2'd1, 0, 0, 2'd0, 2'd1, 2'd0, 0));
      mcyc(A0, 32'h0, 1'b1, 2'd2); tick("R6 read condition rejects write", 1'b0);
      wr(5'd4, ctl(1, 2'd0, 0, 0, 2'd0, 2'd2, 2'd0, 0));
      fcyc(A0); tick("R6 fetch counts as read", 1'b0);

      // R7 size
      wr(5'd4, ctl(1, 2'd1, 0, 0, 2'd0, 2'd0, 2'd2, 0));
      mcyc(A0, 32'h0, 1'b0, 2'd0); tick("R7 word condition rejects byte", 1'b0);
      mcyc(A0, 32'h0, 1'b0, 2'd1); hit0("R7 word matches");
      clr(2'b01);
      wr(5'd4, ctl(1, 2'd0, 0, 0, 2'd0, 2'd0, 2'd3, 0));
      fcyc(A0); hit0("R7 fetch counts as longword");
      clr(2'b01);
      wr(5'd4, ctl(1, 2'd0, 0, 0, 2'd0, 2'd0, 2'd1, 0));
      fcyc(A0); tick("R7 byte condition rejects fetch", 1'b0);

      // R11 back-to-back events
      wr(5'd4, ctl(1, 2'd1, 0, 0, 2'd0, 2'd0, 2'd0, 0));
      mcyc(A0, 32'h0, 1'b0, 2'd2); ef[0] = 1'b1; tick("R11 first event", 1'b1);
      mcyc(A0, 32'h0, 1'b0, 2'd2); tick("R11 second event pulses again", 1'b1);
      tick("R11 pulse ends", 1'b0);
      clr(2'b01);

      // R9 / R8 two channels
      wr(5'd8, A1); wr(5'd9, 32'h0);
      wr(5'd12, ctl(1, 2'd2, 0, 0, 2'd0, 2'd0, 2'd0, 0));
      mcyc(A0, 32'h0, 1'b0, 2'd2); ef = 2'b01; tick("R9 only channel 0 flags", 1'b1);
      tick("R9 idle", 1'b0);
      icyc(A1, 32'h0, 1'b0, 2'd2); ef = 2'b11; tick("R9 channel 1 own flag", 1'b1);
      tick("R8 both flags held", 1'b0);
      clr(2'b01);
      tick("R8 channel 1 held after channel 0 clear", 1'b0);
      icyc(A1, 32'h0, 1'b0, 2'd2);
      cfg_we = 1'b1; cfg_addr = 5'd16; cfg_wdata = 32'd2;
      tick("R8 set wins over same-cycle clear", 1'b1);
      clr(2'b10);
      wr(5'd12, 32'h0);

      // R10 after-execution fetch
      wr(5'd1, 32'h0);
      wr(5'd4, ctl(1, 2'd0, 0, 0, 2'd0, 2'd0, 2'd0, 1));
      fcyc(A0); tick("R10 after-exec fetch waits for retire", 1'b0);
      ret_valid = 1'b1; ret_addr = 32'h1000_0044; tick("R10 retire of other address", 1'b0);
      ret_valid = 1'b1; ret_addr = A0; ef = 2'b01; ea = 2'b01;
      tick("R10 retire of matched fetch", 1'b1);
      tick("R10 indicator held", 1'b0);
      clr(2'b01);
      ret_valid = 1'b1; ret_addr = A0; tick("R10 held entry consumed", 1'b0);
      wr(5'd4, ctl(1, 2'd1, 0, 0, 2'd0, 2'd0, 2'd0, 1));
      mcyc(A0, 32'h0, 1'b0, 2'd2); hit0("R10 data access reported at once");
      clr(2'b01);

      // R12 config write concurrent with a match
      wr(5'd4, ctl(1, 2'd1, 0, 0, 2'd0, 2'd0, 2'd0, 0));
      mcyc(A0, 32'h0, 1'b0, 2'd2);
      cfg_we = 1'b1; cfg_addr = 5'd0; cfg_wdata = 32'h3000_0000;
      hit0("R12 old address used in write cycle");
      clr(2'b01);
      mcyc(A0, 32'h0, 1'b0, 2'd2); tick("R12 old address no longer matches", 1'b0);
      mcyc(32'h3000_0000, 32'h0, 1'b0, 2'd2); hit0("R12 new address matches");
      clr(2'b01);

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule